// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block produces the SCL and SDA waveforms of an I2C master, one bus event at a time. A controller above it sends single commands (start, repeated start, write one bit, read one bit, stop) over a valid/ready pair. The block drives the two lines as open-drain enables: an enable of 1 pulls the line low, 0 releases it. Each command ends with a one-cycle response pulse. For a read, the pulse carries the sampled data bit.

Every phase length is derived from one programmable SCL period P, counted in system clock cycles. The high half is H = floor(P/2) and the low half is L = P - H, with small fixed corrections in system clock cycles. SCL and SDA are read back through a synchronizer. The high-phase count does not begin until the synchronized SCL input has actually risen, so a slow rise or a slave holding SCL low lengthens the high phase.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0, cmd_ready is 1 and rsp_valid is 0.
- R2: Start (cmd_op 0) requires an idle bus. sda_oe goes to 1 on the accepting clock edge. scl_oe goes to 1 exactly H-1 cycles later, and rsp_valid is 1 in the cycle that follows that edge.
- R3: Write (cmd_op 2) drives sda_oe to the inverse of cmd_wdata. SDA changes 3 cycles after the accepting edge while SCL is still held low. scl_oe is released exactly L-3 cycles after the SDA change.
- R4: For a write or a read on a bus whose SCL rises at once, scl_oe returns to 1 exactly H cycles after it was released. rsp_valid is 1 in the cycle after that edge.
- R5: When SCL is held low externally after release, scl_oe returns to 1 exactly H cycles after scl_in goes high, so the high phase is lengthened by the delay.
- R6: Read (cmd_op 3) releases SDA 3 cycles after the accepting edge and keeps it released until completion. rsp_rdata returns the level of sda_in at the midpoint of the SCL high phase.
- R7: Repeated start (cmd_op 1) proceeds as follows. SDA is released 3 cycles after acceptance. SCL is released L-3 cycles later. SDA is pulled low P cycles after the SCL release. SCL is pulled low H-1 cycles after that.
- R8: Stop (cmd_op 4) proceeds as follows. SDA is pulled low 3 cycles after acceptance. SCL is released L-3 cycles later. SDA is released H+2 cycles after the SCL release. rsp_valid follows H-1 cycles after the SDA release, which is the bus-free time.
- R9: P is per_cfg clamped to the range 28 to 256. For an odd P the extra cycle goes to the low phase (H = floor(P/2), L = P - H).
- R10: A command is taken when cmd_valid and cmd_ready are both 1. cmd_ready stays 0 from acceptance until completion, and rsp_valid is a single-cycle pulse that is only raised while cmd_ready is 1. Op codes 5 to 7 complete in the accepting cycle and leave both enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| per_cfg | input | PER_W | Requested SCL period in system clock cycles |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 3 | 0 start, 1 repeated start, 2 write bit, 3 read bit, 4 stop |
| cmd_wdata | input | 1 | Bit value for a write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1 | Bit sampled by the last read |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume three things about the inputs:
- per_cfg stays constant while a command is in progress.
- A start is issued only on an idle bus, that is, after reset or after a stop.
- The line inputs follow the wired-AND of the enables and any external pull-down.

Under these assumptions the checks hold: SDA moves while SCL is released only during start, repeated start and stop, and the high-phase wait lasts until SCL reads high. The stimulus models the bus as a wired-AND, with a slave that pulls SCL low for a fixed stretch and drives SDA only while SCL is low. It changes per_cfg only between command sequences and begins each sequence with a start on a free bus.

// File: rtl/i2c_bt_pkg.sv
`timescale 1ns/1ps
package i2c_bt_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_STOP    = 3'd4
  } bt_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HOLD,
    PH_SETUP,
    PH_RISE,
    PH_HIGH,
    PH_TAIL,
    PH_FREE
  } bt_phase_e;

  // cycles SDA is held after SCL is pulled low
  localparam int unsigned HOLD_CYC = 3;

endpackage

// File: rtl/i2c_bt_period.sv
`timescale 1ns/1ps
module i2c_bt_period #(
  parameter int unsigned PER_W   = 9,
  parameter int unsigned MIN_PER = 28,
  parameter int unsigned MAX_PER = 256
) (
  input  logic [PER_W-1:0] per_cfg,
  output logic [PER_W-1:0] per_eff,
  output logic [PER_W-1:0] half_hi,
  output logic [PER_W-1:0] half_lo
);

  localparam logic [PER_W-1:0] MIN_V = PER_W'(MIN_PER);
  localparam logic [PER_W-1:0] MAX_V = PER_W'(MAX_PER);

  always_comb begin
    if (per_cfg < MIN_V) begin
      per_eff = MIN_V;
    end else if (per_cfg > MAX_V) begin
      per_eff = MAX_V;
    end else begin
      per_eff = per_cfg;
    end
    half_hi = per_eff >> 1;
    half_lo = per_eff - half_hi;   // odd remainder lands in the low half
  end

endmodule

// File: rtl/i2c_bt_sync.sv
`timescale 1ns/1ps
module i2c_bt_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '1;                       // idle bus reads high
      end else begin
        sh_q <= {sh_q[STAGES-2:0], d_in[g]};
      end
    end
    assign d_out[g] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/i2c_bt_seq.sv
`timescale 1ns/1ps
module i2c_bt_seq
  import i2c_bt_pkg::*;
#(
  parameter int unsigned PER_W       = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_wdata,
  input  logic [PER_W-1:0] per_eff,
  input  logic [PER_W-1:0] half_hi,
  input  logic [PER_W-1:0] half_lo,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             rsp_valid,
  output logic             rsp_rdata,
  output bt_phase_e        phase,
  output bt_op_e           op_cur
);

  // release-to-counter latency: output register plus synchronizer stages
  localparam int unsigned LAT = SYNC_STAGES + 1;

  bt_phase_e        phase_q, phase_d;
  bt_op_e           op_q, op_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             scl_q, scl_d;
  logic             sda_q, sda_d;
  logic             wbit_q, wbit_d;
  logic             done_q, done_d;
  logic             rd_q, rd_d;
  logic [PER_W-1:0] high_len;
  logic [PER_W-1:0] sample_at;
  logic             cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign sample_at = half_hi - (half_hi >> 1) - PER_W'(SYNC_STAGES);

  always_comb begin
    case (op_q)
      OP_RESTART: high_len = per_eff;
      OP_STOP:    high_len = half_hi + PER_W'(2);
      default:    high_len = half_hi;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    op_d    = op_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - PER_W'(1);
    scl_d   = scl_q;
    sda_d   = sda_q;
    wbit_d  = wbit_q;
    done_d  = 1'b0;
    rd_d    = rd_q;
    case (phase_q)
      PH_IDLE: begin
        if (cmd_valid) begin
          wbit_d = cmd_wdata;
          case (cmd_op)
            OP_START: begin
              op_d    = OP_START;
              sda_d   = 1'b1;
              phase_d = PH_TAIL;
              cnt_d   = half_hi - PER_W'(2);
            end
            OP_RESTART, OP_WRITE, OP_READ, OP_STOP: begin
              op_d    = bt_op_e'(cmd_op);
              phase_d = PH_HOLD;
              cnt_d   = PER_W'(HOLD_CYC - 1);
            end
            default: done_d = 1'b1;
          endcase
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          case (op_q)
            OP_WRITE: sda_d = ~wbit_q;
            OP_STOP:  sda_d = 1'b1;
            default:  sda_d = 1'b0;
          endcase
          phase_d = PH_SETUP;
          cnt_d   = half_lo - PER_W'(HOLD_CYC + 1);
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          scl_d   = 1'b0;
          phase_d = PH_RISE;
        end
      end
      PH_RISE: begin
        if (scl_s) begin
          phase_d = PH_HIGH;
          cnt_d   = high_len - PER_W'(LAT + 1);
        end
      end
      PH_HIGH: begin
        if ((op_q == OP_READ) && (cnt_q == sample_at)) begin
          rd_d = sda_s;
        end
        if (cnt_zero) begin
          case (op_q)
            OP_RESTART: begin
              sda_d   = 1'b1;
              phase_d = PH_TAIL;
              cnt_d   = half_hi - PER_W'(2);
            end
            OP_STOP: begin
              sda_d   = 1'b0;
              phase_d = PH_FREE;
              cnt_d   = half_hi - PER_W'(2);
            end
            default: begin
              scl_d   = 1'b1;
              done_d  = 1'b1;
              phase_d = PH_IDLE;
            end
          endcase
        end
      end
      PH_TAIL: begin
        if (cnt_zero) begin
          scl_d   = 1'b1;
          done_d  = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      PH_FREE: begin
        if (cnt_zero) begin
          done_d  = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_START;
      cnt_q   <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      wbit_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      wbit_q  <= wbit_d;
      done_q  <= done_d;
      rd_q    <= rd_d;
    end
  end

  assign cmd_ready = (phase_q == PH_IDLE);
  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;
  assign rsp_valid = done_q;
  assign rsp_rdata = rd_q;
  assign phase     = phase_q;
  assign op_cur    = op_q;

endmodule

// File: rtl/i2c_bit_timer.sv
`timescale 1ns/1ps
module i2c_bit_timer
  import i2c_bt_pkg::*;
#(
  parameter int unsigned PER_W       = 9,
  parameter int unsigned MIN_PER     = 28,
  parameter int unsigned MAX_PER     = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] per_cfg,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_wdata,
  output logic             rsp_valid,
  output logic             rsp_rdata,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [PER_W-1:0] per_eff_w, half_hi_w, half_lo_w;
  logic [1:0]       line_s;
  logic             scl_s, sda_s;
  bt_phase_e        phase_w;
  bt_op_e           op_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  i2c_bt_period #(
    .PER_W  (PER_W),
    .MIN_PER(MIN_PER),
    .MAX_PER(MAX_PER)
  ) u_period (
    .per_cfg(per_cfg),
    .per_eff(per_eff_w),
    .half_hi(half_hi_w),
    .half_lo(half_lo_w)
  );

  i2c_bt_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (2)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_in ({sda_in, scl_in}),
    .d_out(line_s)
  );
  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  i2c_bt_seq #(
    .PER_W      (PER_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op),
    .cmd_wdata(cmd_wdata),
    .per_eff  (per_eff_w),
    .half_hi  (half_hi_w),
    .half_lo  (half_lo_w),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .phase    (phase_w),
    .op_cur   (op_w)
  );

endmodule

// File: rtl/i2c_bit_timer_checker.sv
`timescale 1ns/1ps
module i2c_bit_timer_checker
  import i2c_bt_pkg::*;
#(
  parameter int unsigned PER_W   = 9,
  parameter int unsigned MIN_PER = 28,
  parameter int unsigned MAX_PER = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic             rsp_valid,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             scl_s,
  input bt_phase_e        phase,
  input bt_op_e           op_cur,
  input logic [PER_W-1:0] per_eff
);

  // R9: effective period always inside the legal window
  p_period_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (per_eff >= PER_W'(MIN_PER)) && (per_eff <= PER_W'(MAX_PER)));

  // R10: a real command makes the block busy on the next cycle
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op <= 3'd4)) |=> !cmd_ready);

  // R10: completion is only signalled once idle again
  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cmd_ready);

  // R3: SDA keeps its level on the cycle after SCL is pulled low
  p_sda_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |=> $stable(sda_oe));

  // R2, R7, R8: SDA moves with SCL released only for start, restart, stop
  p_sda_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe) |-> ((phase == PH_TAIL) || (phase == PH_FREE)));

  // R5: the high phase is not entered while SCL still reads low
  p_wait_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_RISE) && !scl_s) |=> (phase == PH_RISE));

  // R4: SCL stays released while the high phase is counted
  p_high_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH) |-> !scl_oe);

  // R6: SDA released through a read bit
  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_cur == OP_READ) &&
     ((phase == PH_SETUP) || (phase == PH_RISE) || (phase == PH_HIGH))) |-> !sda_oe);

endmodule

bind i2c_bit_timer i2c_bit_timer_checker #(
  .PER_W  (PER_W),
  .MIN_PER(MIN_PER),
  .MAX_PER(MAX_PER)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_op   (cmd_op),
  .rsp_valid(rsp_valid),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .scl_s    (scl_s),
  .phase    (phase_w),
  .op_cur   (op_w),
  .per_eff  (per_eff_w)
);

// File: tb/i2c_bit_timer_bench.sv
`timescale 1ns/1ps
module i2c_bit_timer_bench;

  localparam int PER_W = 9;

  logic             clk;
  logic             rst_n;
  logic [PER_W-1:0] per_cfg;
  logic             cmd_valid;
  logic             cmd_ready;
  logic [2:0]       cmd_op;
  logic             cmd_wdata;
  logic             rsp_valid;
  logic             rsp_rdata;
  logic             scl_in, sda_in;
  logic             scl_oe, sda_oe;
  logic             stretch;
  logic             slave_bit;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t_scl_dn, t_scl_up, t_sda_dn, t_sda_up;
  logic prev_scl, prev_sda;
  int P, H, L;

  // wired-AND bus with a slave able to hold either line low
  assign scl_in = ~scl_oe & ~stretch;
  assign sda_in = ~sda_oe & slave_bit;

  i2c_bit_timer u_i2c_bit_timer (
    .clk(clk), .rst_n(rst_n), .per_cfg(per_cfg),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // edge recorder: cyc at a negedge counts the posedges so far
  always @(negedge clk) begin
    if (scl_oe && !prev_scl) t_scl_dn = cyc;
    if (!scl_oe && prev_scl) t_scl_up = cyc;
    if (sda_oe && !prev_sda) t_sda_dn = cyc;
    if (!sda_oe && prev_sda) t_sda_up = cyc;
    prev_scl = scl_oe;
    prev_sda = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_period(input int cfg);
    per_cfg = cfg[PER_W-1:0];
    P = (cfg < 28) ? 28 : (cfg > 256) ? 256 : cfg;
    H = P / 2;
    L = P - H;
  endtask

  task automatic issue(input logic [2:0] op, input logic b, output int acc);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_wdata = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    acc = cyc;
    #1;
    chk("R10 busy after accept", int'(cmd_ready), (op <= 3'd4) ? 0 : 1);
  endtask

  task automatic wait_rsp(output int t, output logic d);
    while (!rsp_valid) @(negedge clk);
    t = cyc;
    d = rsp_rdata;
    #1;
  endtask

  task automatic test_reset();
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic test_start();
    int a, t; logic d;
    issue(3'd0, 1'b0, a);
    wait_rsp(t, d);
    chk("R2 sda low on accept", t_sda_dn, a);
    chk("R2 scl low after H-1", t_scl_dn - t_sda_dn, H - 1);
    chk("R2 rsp with scl low", t, t_scl_dn);
  endtask

  task automatic test_write(input logic b);
    int a, t, ts; logic d;
    issue(3'd2, b, a);
    wait_rsp(t, d);
    ts = b ? t_sda_up : t_sda_dn;
    chk("R3 sda change 3 after accept", ts, a + 3);
    chk("R3 R9 setup L-3", t_scl_up - ts, L - 3);
    chk("R4 R9 high H", t_scl_dn - t_scl_up, H);
    chk("R4 rsp with scl low", t, t_scl_dn);
  endtask

  task automatic test_restart();
    int a, t; logic d;
    issue(3'd1, 1'b0, a);
    wait_rsp(t, d);
    chk("R7 sda release", t_sda_up, a + 3);
    chk("R7 setup L-3", t_scl_up - t_sda_up, L - 3);
    chk("R7 scl high P before sda low", t_sda_dn - t_scl_up, P);
    chk("R7 scl low H-1 after sda", t_scl_dn - t_sda_dn, H - 1);
  endtask

  task automatic test_read(input logic sbit, input logic was_low);
    int a, t; logic d;
    slave_bit = sbit;
    issue(3'd3, 1'b0, a);
    wait_rsp(t, d);
    if (was_low) chk("R6 sda released 3 after accept", t_sda_up, a + 3);
    chk("R6 sda still released", int'(sda_oe), 0);
    chk("R6 read data", int'(d), int'(sbit));
    chk("R4 read high H", t_scl_dn - t_scl_up, H);
    slave_bit = 1'b1;
  endtask

  task automatic test_stop();
    int a, t; logic d;
    issue(3'd4, 1'b0, a);
    wait_rsp(t, d);
    chk("R8 sda low 3 after accept", t_sda_dn, a + 3);
    chk("R8 setup L-3", t_scl_up - t_sda_dn, L - 3);
    chk("R8 stop setup H+2", t_sda_up - t_scl_up, H + 2);
    chk("R8 bus free H-1", t - t_sda_up, H - 1);
  endtask

  task automatic test_frame(input int cfg);
    set_period(cfg);
    test_start();
    test_write(1'b1);
    test_write(1'b0);
    test_restart();
    test_read(1'b0, 1'b1);
    test_read(1'b1, 1'b0);
    test_stop();
  endtask

  task automatic test_stretch();
    int a, t, cr; logic d;
    set_period(60);
    test_start();
    issue(3'd2, 1'b1, a);
    while (scl_oe) @(negedge clk);
    stretch = 1'b1;
    repeat (10) @(negedge clk);
    stretch = 1'b0;
    cr = cyc;
    wait_rsp(t, d);
    chk("R5 high counted from input rise", t_scl_dn - cr, H);
    chk("R5 high lengthened", t_scl_dn - t_scl_up, H + 10);
    test_stop();
  endtask

  task automatic test_bad_op();
    int a, t; logic d;
    int s_dn, s_up, d_dn, d_up;
    s_dn = t_scl_dn; s_up = t_scl_up; d_dn = t_sda_dn; d_up = t_sda_up;
    issue(3'd6, 1'b0, a);
    wait_rsp(t, d);
    chk("R10 undefined op completes at once", t, a);
    repeat (5) @(negedge clk);
    #1;
    chk("R10 undefined op scl untouched", int'(scl_oe), 0);
    chk("R10 undefined op sda untouched", int'(sda_oe), 0);
    chk("R10 no edge recorded", int'((s_dn == t_scl_dn) && (s_up == t_scl_up) &&
                                     (d_dn == t_sda_dn) && (d_up == t_sda_up)), 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = 3'd0;
    cmd_wdata = 1'b0;
    stretch = 1'b0;
    slave_bit = 1'b1;
    prev_scl = 1'b0;
    prev_sda = 1'b0;
    t_scl_dn = -1; t_scl_up = -1; t_sda_dn = -1; t_sda_up = -1;
    set_period(40);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    test_reset();
    test_frame(10);    // R9 clamp low
    test_frame(41);    // R9 odd split
    test_frame(300);   // R9 clamp high
    test_stretch();
    test_bad_op();
    finish_run();
  end

endmodule